// File: doc/BRIEF.md
# Terminal Interrupt and Status Control

This block joins a small memory-mapped character terminal to the part of a processor that decides whether an interrupt is taken. On the device side it holds a received character with a ready flag and a device interrupt enable. It also has a transmit side that reports whether the terminal can accept a character and launches a write to it. On the processor side it keeps a status register and a cause register. The status register holds a six-bit stack of interrupt-enable and user-mode pairs plus an interrupt mask. The cause register shows which interrupt lines are pending and the code of the last exception taken.

The processor core signals exception entry and return with one-cycle strobes. Entry pushes the enable/mode stack by two bit positions, so interrupts are disabled and kernel mode is entered, and it records the exception code. Return pops the stack back. Software reaches the terminal words through a simple word bus and reaches the status and cause registers through a separate register port. The block raises `irqReq` while any pending line is unmasked and interrupts are globally enabled.

Top module: `term_irq_ctrl`

## Requirements
- R1: After reset the status word, the cause word and the receive control word all read 0, `irqReq` is 0, `kernelMode` is 1 and `txStrobe` is 0.
- R2: A cycle with `rxValid` high stores `rxChar` and sets the ready flag. The ready flag is bit 0 of the receive control word at byte address BASE (0xFFFF0000), and the character reads in the low bits of the word at BASE+4.
- R3: A bus read of BASE+4 clears the ready flag. If a new character arrives in the same cycle, the flag stays 1 and the new character is kept.
- R4: Bit 1 of the receive control word is the device interrupt enable, writable by software. A bus write to that word leaves the ready flag unchanged.
- R5: Cause bit 8 equals ready AND device enable. Cause bits 9..15 follow `otherIrq[0..6]` as levels, with no latching.
- R6: `irqReq` is 1 exactly when some cause bit 8+i is set together with status mask bit 8+i and status bit 0 (the global enable).
- R7: On `excEnter`, status bits 5..0 become {old bits 3..0, 00} and `excCode` is latched into cause bits 5..2. Code 0 means an external interrupt.
- R8: On `excReturn`, status bits 3..0 take old bits 5..2 and bits 5..4 keep their value. If entry and return arrive together, entry wins.
- R9: `kernelMode` is 1 exactly when status bit 1 (the current user-mode bit) is 0.
- R10: Bit 0 of the word at BASE+8 reflects `txReady`. A bus write to BASE+12 while `txReady` is 1 gives `txStrobe` high for one cycle after the write edge, with the written character on `txChar`. The same write while `txReady` is 0 is dropped.
- R11: Writes to the cause register are ignored. Status bits 7..6 and 31..16 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the terminal word |
| busWrEn | input | 1 | Terminal word write strobe |
| busRdEn | input | 1 | Terminal word read strobe (read side effects) |
| busWrData | input | 32 | Terminal write data |
| busRdData | output | 32 | Terminal read data, combinational from address |
| copSel | input | 1 | Register port select: 0 status, 1 cause |
| copWrEn | input | 1 | Register port write strobe |
| copWrData | input | 32 | Register port write data |
| copRdData | output | 32 | Register port read data, combinational |
| excEnter | input | 1 | Exception entry strobe |
| excReturn | input | 1 | Return-from-exception strobe |
| excCode | input | 4 | Exception code latched on entry |
| otherIrq | input | 7 | Interrupt lines 1..7, level sensitive |
| rxValid | input | 1 | Received character valid |
| rxChar | input | 8 | Received character |
| txReady | input | 1 | Terminal can accept a character |
| txChar | output | 8 | Character sent to the terminal |
| txStrobe | output | 1 | One-cycle send pulse |
| irqReq | output | 1 | Interrupt request to the core |
| kernelMode | output | 1 | Processor is in kernel mode |

## Verification
Reads on both ports, the pending bits driven by `otherIrq`, and `irqReq` are combinational. The bench therefore samples them one time unit after it changes an input, well before the next rising edge. Register updates (ready flag, enables, stack pushes and pops, the exception code) take effect at the rising edge that samples the strobe. The bench drives each strobe at a falling edge and checks the result at the following falling edge. `txStrobe` is registered at the edge that takes the write, so it is checked at the falling edge right after that write edge and again one cycle later to see that it has dropped.

// File: rtl/tic_pkg.sv
`timescale 1ns/1ps
package tic_pkg;
  localparam int STACK_W  = 6;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 2;
  localparam int LINE_LSB = 8;

  localparam logic [1:0] IDX_RXCTRL = 2'd0;
  localparam logic [1:0] IDX_RXDATA = 2'd1;
  localparam logic [1:0] IDX_TXCTRL = 2'd2;
  localparam logic [1:0] IDX_TXDATA = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXCTRL,
    SEL_RXDATA,
    SEL_TXCTRL,
    SEL_TXDATA
  } busSel_t;

  typedef struct packed {
    logic wrRxCtrl;
    logic rdRxData;
    logic wrTxData;
  } devStrobe_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic wrStatus;
  } excStrobe_t;
endpackage

// File: rtl/tic_ctrl.sv
`timescale 1ns/1ps
module tic_ctrl
  import tic_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              copWrEn,
  input  logic              copSel,
  input  logic              excEnter,
  input  logic              excReturn,
  output devStrobe_t        devStrb,
  output excStrobe_t        excStrb,
  output busSel_t           rdSel
);
  localparam int PAGE_LSB = 4;

  logic       inPage;
  logic [1:0] wordIdx;

  assign inPage  = (busAddr[ADDR_W-1:PAGE_LSB] == BASE_ADDR[ADDR_W-1:PAGE_LSB])
                && (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[3:2];

  always_comb begin
    rdSel = SEL_NONE;
    if (inPage) begin
      case (wordIdx)
        IDX_RXCTRL: rdSel = SEL_RXCTRL;
        IDX_RXDATA: rdSel = SEL_RXDATA;
        IDX_TXCTRL: rdSel = SEL_TXCTRL;
        IDX_TXDATA: rdSel = SEL_TXDATA;
        default:    rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    devStrb.wrRxCtrl = busWrEn & (rdSel == SEL_RXCTRL);
    devStrb.rdRxData = busRdEn & (rdSel == SEL_RXDATA);
    devStrb.wrTxData = busWrEn & (rdSel == SEL_TXDATA);
  end

  // entry beats return, both beat a software write of the status word
  always_comb begin
    excStrb.push     = excEnter;
    excStrb.pop      = excReturn & ~excEnter;
    excStrb.wrStatus = copWrEn & ~copSel & ~excEnter & ~excReturn;
  end
endmodule

// File: rtl/tic_dev_regs.sv
`timescale 1ns/1ps
module tic_dev_regs
  import tic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  devStrobe_t        strb,
  input  busSel_t           rdSel,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              txReady,
  output logic [DATA_W-1:0] busRdData,
  output logic [CHAR_W-1:0] txChar,
  output logic              txStrobe,
  output logic              rxReady,
  output logic              devIrq
);
  localparam int READY_BIT = 0;
  localparam int IE_BIT    = 1;

  logic              rxReadyQ;
  logic              rxIeQ;
  logic [CHAR_W-1:0] rxDataQ;
  logic [CHAR_W-1:0] txCharQ;
  logic              txStrobeQ;
  logic              txAccept;
  logic              unusedWrBits;

  assign txAccept     = strb.wrTxData & txReady;
  assign unusedWrBits = ^busWrData[DATA_W-1:CHAR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReadyQ  <= 1'b0;
      rxIeQ     <= 1'b0;
      rxDataQ   <= '0;
      txCharQ   <= '0;
      txStrobeQ <= 1'b0;
    end else begin
      if (rxValid) begin
        rxReadyQ <= 1'b1;
        rxDataQ  <= rxChar;
      end else if (strb.rdRxData) begin
        rxReadyQ <= 1'b0;
      end
      if (strb.wrRxCtrl) rxIeQ <= busWrData[IE_BIT];
      txStrobeQ <= txAccept;
      if (txAccept) txCharQ <= busWrData[CHAR_W-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    case (rdSel)
      SEL_RXCTRL: begin
        busRdData[READY_BIT] = rxReadyQ;
        busRdData[IE_BIT]    = rxIeQ;
      end
      SEL_RXDATA: busRdData[CHAR_W-1:0] = rxDataQ;
      SEL_TXCTRL: busRdData[READY_BIT]  = txReady;
      default:    busRdData = '0;
    endcase
  end

  assign txChar   = txCharQ;
  assign txStrobe = txStrobeQ;
  assign rxReady  = rxReadyQ;
  assign devIrq   = rxReadyQ & rxIeQ;
endmodule

// File: rtl/tic_exc_state.sv
`timescale 1ns/1ps
module tic_exc_state
  import tic_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  excStrobe_t           strb,
  input  logic                 copSel,
  input  logic [DATA_W-1:0]    copWrData,
  input  logic [CODE_W-1:0]    excCode,
  input  logic                 devIrq,
  input  logic [NUM_LINES-2:0] otherIrq,
  output logic [DATA_W-1:0]    copRdData,
  output logic                 irqReq,
  output logic                 kernelMode,
  output logic [STACK_W-1:0]   stackBits
);
  localparam int IE_CUR = 0;
  localparam int KU_CUR = 1;

  logic [STACK_W-1:0]   stackQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [CODE_W-1:0]    codeQ;
  logic [NUM_LINES-1:0] pending;
  logic                 unusedWrBits;

  assign pending      = {otherIrq, devIrq};
  assign unusedWrBits = ^{copWrData[LINE_LSB-1:STACK_W],
                          copWrData[DATA_W-1:LINE_LSB+NUM_LINES]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackQ <= '0;
      maskQ  <= '0;
      codeQ  <= '0;
    end else if (strb.push) begin
      stackQ <= {stackQ[STACK_W-3:0], 2'b00};
      codeQ  <= excCode;
    end else if (strb.pop) begin
      stackQ <= {stackQ[STACK_W-1:STACK_W-2], stackQ[STACK_W-1:2]};
    end else if (strb.wrStatus) begin
      stackQ <= copWrData[STACK_W-1:0];
      maskQ  <= copWrData[LINE_LSB +: NUM_LINES];
    end
  end

  always_comb begin
    copRdData = '0;
    if (copSel) begin
      copRdData[LINE_LSB +: NUM_LINES] = pending;
      copRdData[CODE_LSB +: CODE_W]    = codeQ;
    end else begin
      copRdData[STACK_W-1:0]           = stackQ;
      copRdData[LINE_LSB +: NUM_LINES] = maskQ;
    end
  end

  assign irqReq     = stackQ[IE_CUR] & (|(pending & maskQ));
  assign kernelMode = ~stackQ[KU_CUR];
  assign stackBits  = stackQ;
endmodule

// File: rtl/term_irq_ctrl.sv
`timescale 1ns/1ps
module term_irq_ctrl
  import tic_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CHAR_W    = 8,
  parameter int NUM_LINES = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic                 copSel,
  input  logic                 copWrEn,
  input  logic [DATA_W-1:0]    copWrData,
  output logic [DATA_W-1:0]    copRdData,
  input  logic                 excEnter,
  input  logic                 excReturn,
  input  logic [CODE_W-1:0]    excCode,
  input  logic [NUM_LINES-2:0] otherIrq,
  input  logic                 rxValid,
  input  logic [CHAR_W-1:0]    rxChar,
  input  logic                 txReady,
  output logic [CHAR_W-1:0]    txChar,
  output logic                 txStrobe,
  output logic                 irqReq,
  output logic                 kernelMode
);
  devStrobe_t         devStrb;
  excStrobe_t         excStrb;
  busSel_t            rdSel;
  logic               devIrq;
  logic               rxReady;
  logic [STACK_W-1:0] stackBits;

  tic_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .copWrEn  (copWrEn),
    .copSel   (copSel),
    .excEnter (excEnter),
    .excReturn(excReturn),
    .devStrb  (devStrb),
    .excStrb  (excStrb),
    .rdSel    (rdSel)
  );

  tic_dev_regs #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_dev (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (devStrb),
    .rdSel    (rdSel),
    .busWrData(busWrData),
    .rxValid  (rxValid),
    .rxChar   (rxChar),
    .txReady  (txReady),
    .busRdData(busRdData),
    .txChar   (txChar),
    .txStrobe (txStrobe),
    .rxReady  (rxReady),
    .devIrq   (devIrq)
  );

  tic_exc_state #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) i_exc (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (excStrb),
    .copSel    (copSel),
    .copWrData (copWrData),
    .excCode   (excCode),
    .devIrq    (devIrq),
    .otherIrq  (otherIrq),
    .copRdData (copRdData),
    .irqReq    (irqReq),
    .kernelMode(kernelMode),
    .stackBits (stackBits)
  );
endmodule

// File: rtl/term_irq_chk.sv
`timescale 1ns/1ps
module term_irq_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic              rxValid,
  input logic              rxReady,
  input logic              excEnter,
  input logic              excReturn,
  input logic [5:0]        stackBits,
  input logic              irqReq,
  input logic              kernelMode
);
  logic rdRx;
  assign rdRx = busRdEn && (busAddr == BASE_ADDR + ADDR_W'(4));

  // R7
  push_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> stackBits == {$past(stackBits[3:0]), 2'b00});

  // R8
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !excEnter) |=> stackBits == {$past(stackBits[5:4]), $past(stackBits[5:2])});

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> stackBits[0]);

  // R2
  rx_sets_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxReady);

  // R3
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && !rxValid) |=> !rxReady);

  // R9
  entry_kernel_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEnter |=> (kernelMode && !irqReq));
endmodule

bind term_irq_ctrl term_irq_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdEn   (busRdEn),
  .rxValid   (rxValid),
  .rxReady   (rxReady),
  .excEnter  (excEnter),
  .excReturn (excReturn),
  .stackBits (stackBits),
  .irqReq    (irqReq),
  .kernelMode(kernelMode)
);

// File: tb/test_term_irq_ctrl.sv
`timescale 1ns/1ps
module test_term_irq_ctrl;
  localparam logic [31:0] RX_CTRL = 32'hFFFF_0000;
  localparam logic [31:0] RX_DATA = 32'hFFFF_0004;
  localparam logic [31:0] TX_CTRL = 32'hFFFF_0008;
  localparam logic [31:0] TX_DATA = 32'hFFFF_000C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        copSel = 1'b0;
  logic        copWrEn = 1'b0;
  logic [31:0] copWrData = '0;
  logic [31:0] copRdData;
  logic        excEnter = 1'b0;
  logic        excReturn = 1'b0;
  logic [3:0]  excCode = '0;
  logic [6:0]  otherIrq = '0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxChar = '0;
  logic        txReady = 1'b1;
  logic [7:0]  txChar;
  logic        txStrobe;
  logic        irqReq;
  logic        kernelMode;

  int  nChecks = 0;
  int  nErrs = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  term_irq_ctrl i_term_irq_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .copSel(copSel), .copWrEn(copWrEn), .copWrData(copWrData), .copRdData(copRdData),
    .excEnter(excEnter), .excReturn(excReturn), .excCode(excCode),
    .otherIrq(otherIrq), .rxValid(rxValid), .rxChar(rxChar),
    .txReady(txReady), .txChar(txChar), .txStrobe(txStrobe),
    .irqReq(irqReq), .kernelMode(kernelMode)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic peekBus(input logic [31:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic peekCop(input logic sel, output logic [31:0] d);
    copSel = sel;
    #1;
    d = copRdData;
  endtask

  task automatic busWrite(input logic [31:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick;
    busWrEn = 1'b0;
  endtask

  task automatic busReadClr(input logic [31:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    tick;
    busRdEn = 1'b0;
  endtask

  task automatic copWrite(input logic sel, input logic [31:0] d);
    copSel = sel; copWrData = d; copWrEn = 1'b1;
    tick;
    copWrEn = 1'b0;
  endtask

  task automatic recvChar(input logic [7:0] c);
    rxValid = 1'b1; rxChar = c;
    tick;
    rxValid = 1'b0;
  endtask

  task automatic enterExc(input logic [3:0] code);
    excEnter = 1'b1; excCode = code;
    tick;
    excEnter = 1'b0;
  endtask

  task automatic returnExc;
    excReturn = 1'b1;
    tick;
    excReturn = 1'b0;
  endtask

  task automatic testReset;
    logic [31:0] d;
    peekCop(1'b0, d); check("R1 status after reset", d, 32'h0);
    peekCop(1'b1, d); check("R1 cause after reset", d, 32'h0);
    peekBus(RX_CTRL, d); check("R1 rx control after reset", d, 32'h0);
    check("R1 irqReq after reset", {31'b0, irqReq}, 32'h0);
    check("R1 kernelMode after reset", {31'b0, kernelMode}, 32'h1);
    check("R1 txStrobe after reset", {31'b0, txStrobe}, 32'h0);
  endtask

  task automatic testRxReceive;
    logic [31:0] d;
    recvChar(8'h41);
    peekBus(RX_CTRL, d); check("R2 ready set", d, 32'h1);
    peekBus(RX_DATA, d); check("R2 char readable", d, 32'h41);
    busReadClr(RX_DATA, d); check("R3 read returns char", d, 32'h41);
    peekBus(RX_CTRL, d); check("R3 ready cleared by read", d, 32'h0);
  endtask

  task automatic testRxCtrlWrite;
    logic [31:0] d;
    busWrite(RX_CTRL, 32'h3);
    peekBus(RX_CTRL, d); check("R4 enable set, ready untouched", d, 32'h2);
  endtask

  task automatic testIrqGate;
    logic [31:0] d;
    copWrite(1'b0, 32'h101);
    recvChar(8'h42);
    #1; check("R6 irq when ready, enables, mask", {31'b0, irqReq}, 32'h1);
    peekCop(1'b1, d); check("R5 cause pending line 0", d, 32'h100);
    copWrite(1'b0, 32'h001);
    #1; check("R6 masked line", {31'b0, irqReq}, 32'h0);
    copWrite(1'b0, 32'h100);
    #1; check("R6 global enable off", {31'b0, irqReq}, 32'h0);
    copWrite(1'b0, 32'h101);
    #1; check("R6 re-enabled", {31'b0, irqReq}, 32'h1);
    busWrite(RX_CTRL, 32'h0);
    #1; check("R4 device enable off blocks irq", {31'b0, irqReq}, 32'h0);
    peekCop(1'b1, d); check("R5 pending drops with device enable", d, 32'h0);
    busWrite(RX_CTRL, 32'h2);
    #1; check("R6 device enable back", {31'b0, irqReq}, 32'h1);
    busReadClr(RX_DATA, d); check("R3 char before clear", d, 32'h42);
    #1; check("R3 irq drops after read", {31'b0, irqReq}, 32'h0);
  endtask

  task automatic testSimulRead;
    logic [31:0] d;
    recvChar(8'h50);
    rxValid = 1'b1; rxChar = 8'h55; busAddr = RX_DATA; busRdEn = 1'b1;
    tick;
    rxValid = 1'b0; busRdEn = 1'b0;
    peekBus(RX_CTRL, d); check("R3 new char keeps ready", d, 32'h3);
    peekBus(RX_DATA, d); check("R3 new char kept", d, 32'h55);
    busReadClr(RX_DATA, d);
    peekBus(RX_CTRL, d); check("R3 final clear", d, 32'h2);
  endtask

  task automatic testPushPop;
    logic [31:0] d;
    copWrite(1'b0, 32'h010B);
    #1; check("R9 user mode before entry", {31'b0, kernelMode}, 32'h0);
    enterExc(4'h0);
    peekCop(1'b0, d); check("R7 push shifts by two", d, 32'h012C);
    check("R9 kernel after entry", {31'b0, kernelMode}, 32'h1);
    peekCop(1'b1, d); check("R7 external code 0", d, 32'h0);
    returnExc;
    peekCop(1'b0, d); check("R8 pop restores", d, 32'h012B);
    check("R9 user after return", {31'b0, kernelMode}, 32'h0);
    enterExc(4'h5);
    peekCop(1'b1, d); check("R7 code latched", d, 32'h14);
    enterExc(4'h0);
    peekCop(1'b0, d); check("R7 nested push", d, 32'h0130);
    returnExc;
    peekCop(1'b0, d); check("R8 old pair kept on pop", d, 32'h013C);
    excEnter = 1'b1; excReturn = 1'b1; excCode = 4'h0;
    tick;
    excEnter = 1'b0; excReturn = 1'b0;
    peekCop(1'b0, d); check("R8 entry wins over return", d, 32'h0130);
    copWrite(1'b0, 32'h01C3);
    peekCop(1'b0, d); check("R11 status bits 7..6 read 0", d, 32'h0103);
    copWrite(1'b0, 32'hFFFF_0101);
    peekCop(1'b0, d); check("R11 status upper bits read 0", d, 32'h0101);
  endtask

  task automatic testCauseWrite;
    logic [31:0] d;
    copWrite(1'b1, 32'hFFFF_FFFF);
    peekCop(1'b1, d); check("R11 cause write ignored", d, 32'h0);
    peekCop(1'b0, d); check("R11 cause write leaves status", d, 32'h0101);
  endtask

  task automatic testPending;
    logic [31:0] d;
    otherIrq = 7'b000_0001;
    peekCop(1'b1, d); check("R5 line 1 pending", d, 32'h0200);
    check("R6 line 1 masked", {31'b0, irqReq}, 32'h0);
    copWrite(1'b0, 32'h0201);
    #1; check("R6 line 1 unmasked", {31'b0, irqReq}, 32'h1);
    otherIrq = 7'b000_0000;
    peekCop(1'b1, d); check("R5 pending follows level", d, 32'h0);
    check("R6 irq drops with line", {31'b0, irqReq}, 32'h0);
  endtask

  task automatic testTx;
    logic [31:0] d;
    txReady = 1'b1;
    peekBus(TX_CTRL, d); check("R10 tx ready bit", d, 32'h1);
    busWrite(TX_DATA, 32'h5A);
    check("R10 strobe after write", {31'b0, txStrobe}, 32'h1);
    check("R10 char sent", {24'b0, txChar}, 32'h5A);
    tick;
    check("R10 strobe one cycle", {31'b0, txStrobe}, 32'h0);
    txReady = 1'b0;
    peekBus(TX_CTRL, d); check("R10 tx not ready", d, 32'h0);
    busWrite(TX_DATA, 32'h33);
    check("R10 write dropped when busy", {31'b0, txStrobe}, 32'h0);
    check("R10 char held", {24'b0, txChar}, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testRxReceive;
    testRxCtrlWrite;
    testIrqGate;
    testSimulRead;
    testPushPop;
    testCauseWrite;
    testPending;
    testTx;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end
endmodule